// File: doc/BRIEF.md
# Video Scroll Address Register Unit

This block keeps the scroll and memory-address state of a tile-based picture processor. It holds three pieces of state. The first is a 15-bit staging address `t`, which also names the top-left tile of the screen. The second is the live video-memory address `v`. The third is a toggle that tracks whether the next byte sent to the address port is the first or the second of a pair. The CPU drives the block through a register select, a data byte and separate write and read strobes. The video timing generator sends two single-cycle strobes: one at the start of horizontal blanking, and one during the sync period of the pre-render line.

CPU writes to the control register change only the nametable field of `t` and the address step. A pair of writes to the address port rewrites `t` and then copies it into `v`. Each CPU access to the data port advances `v` by 1 or by 32. When rendering is on, the raster strobes copy the horizontal or the vertical fields of `t` into `v`. This restores the scroll position for each line and for each frame. Writing zero twice to the address port clears both registers, so a later raster reload selects the first nametable.

Top module: `scroll_addr_unit`

## Requirements
- R1: After reset, `t`, `v`, the step bit and the write toggle are all zero, so `live_v` and `vram_addr` read 0.
- R2: A write to the control register (select 0) copies data bits 1:0 into `t` bits 11:10 and leaves every other bit of `t` unchanged.
- R3: Control data bit 2 sets the step. Each data-port access (select 7, read or write) adds 32 to `v` when the step bit is 1, and adds 1 when it is 0.
- R4: A first write to the address port (select 6) loads `t` bits 13:8 from data bits 5:0 and clears `t` bit 14. It leaves `v` unchanged.
- R5: A second write to the address port loads `t` bits 7:0 from the data byte. In the same cycle `v` takes the complete new value of `t`.
- R6: The toggle flips on every address-port write. A read of the status register (select 2) returns it to the first-write state.
- R7: A horizontal-blank strobe while rendering is enabled copies `t` bits 4:0 and bit 10 into `v`. The other bits of `v` are kept.
- R8: A pre-render sync strobe while rendering is enabled copies `t` bits 9:5, 11 and 14:12 into `v`. The other bits of `v` are kept.
- R9: While rendering is disabled, both raster strobes leave `v` unchanged.
- R10: `vram_addr` equals `v` bits 13:0. Increments wrap modulo 2^15.
- R11: If a CPU action that changes `v` (a second address write or a data-port access) occurs in the same cycle as a raster strobe, the CPU action wins and the strobe is ignored for that cycle.
- R12: Writing 0x00 twice to the address port leaves `t` and `v` at zero, including nametable bits 11:10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU register write strobe |
| cpu_rd | input | 1 | CPU register read strobe |
| cpu_sel | input | SEL_W | Register select |
| cpu_wdata | input | 8 | CPU write data |
| render_en | input | 1 | Rendering enabled; gates the raster reloads |
| hblank_stb | input | 1 | Start-of-horizontal-blank strobe |
| presync_stb | input | 1 | Pre-render line sync strobe |
| vram_addr | output | OUT_W | Video-memory address, `v` bits 13:0 |
| live_v | output | 15 | Full live address `v` |

## Verification
The bench reads back hidden `t` bits by firing both raster strobes together with rendering on, which copies all of `t` into `v`. This shows a control write that disturbed other fields of `t`, and a first address write that leaked into `v` or kept bit 14. It performs a status read between the two halves of an address pair; a design that ignored that reset would load `v` one write early. It also drives a raster strobe in the same cycle as a second address write or a data access, where a wrong priority corrupts `v`. A full 32-step run through bit 14 to zero catches an increment that saturates or wraps at 14 bits.

// File: rtl/scroll_addr_pkg.sv
package scroll_addr_pkg;
   // Address width is fixed by the field layout that the raster reloads decode
   localparam int unsigned VA_W = 15;
   typedef logic [VA_W-1:0] vaddr_t;

   // coarse X (4:0) and horizontal nametable bit (10)
   localparam vaddr_t HORIZ_MASK = 15'h041F;
   // coarse Y (9:5), vertical nametable bit (11), fine Y (14:12)
   localparam vaddr_t VERT_MASK  = 15'h7BE0;
endpackage

// File: rtl/scroll_cpu_port.sv
module scroll_cpu_port
   import scroll_addr_pkg::*;
#(
   parameter int unsigned SEL_W      = 3,
   parameter int unsigned SEL_CTRL   = 0,
   parameter int unsigned SEL_STATUS = 2,
   parameter int unsigned SEL_ADDR   = 6,
   parameter int unsigned SEL_DATA   = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic             rd,
   input  logic [SEL_W-1:0] sel,
   input  logic [7:0]       wdata,
   output vaddr_t           t_q,
   output logic             step_q,
   output logic             load_v,
   output vaddr_t           load_val,
   output logic             inc_v
);
   localparam logic [SEL_W-1:0] S_CTRL = SEL_W'(SEL_CTRL);
   localparam logic [SEL_W-1:0] S_STAT = SEL_W'(SEL_STATUS);
   localparam logic [SEL_W-1:0] S_ADDR = SEL_W'(SEL_ADDR);
   localparam logic [SEL_W-1:0] S_DATA = SEL_W'(SEL_DATA);

   vaddr_t t_d;
   logic   step_d, tog_q, tog_d;

   always_comb begin
      t_d    = t_q;
      step_d = step_q;
      tog_d  = tog_q;
      load_v = 1'b0;
      inc_v  = 1'b0;
      if (wr && sel == S_CTRL) begin
         t_d[11:10] = wdata[1:0];
         step_d     = wdata[2];
      end
      if (wr && sel == S_ADDR) begin
         if (!tog_q) begin
            t_d[14:8] = {1'b0, wdata[5:0]};
         end else begin
            t_d[7:0] = wdata;
            load_v   = 1'b1;
         end
         tog_d = ~tog_q;
      end
      if ((wr || rd) && sel == S_DATA) inc_v = 1'b1;
      if (rd && sel == S_STAT) tog_d = 1'b0;
   end

   assign load_val = t_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         t_q    <= '0;
         step_q <= 1'b0;
         tog_q  <= 1'b0;
      end else begin
         t_q    <= t_d;
         step_q <= step_d;
         tog_q  <= tog_d;
      end
   end

   AST_CTRL_NT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel == S_CTRL) |=> (t_q[11:10] == $past(wdata[1:0]) &&
                                 t_q[9:0] == $past(t_q[9:0]) &&
                                 t_q[14:12] == $past(t_q[14:12])));   // R2
   AST_FIRST_WR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel == S_ADDR && !tog_q) |=> (t_q[13:8] == $past(wdata[5:0]) &&
                                           !t_q[14] && tog_q));       // R4
   AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel == S_ADDR) |=> (tog_q != $past(tog_q)));             // R6
   AST_STATUS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && sel == S_STAT && !wr) |=> !tog_q);                       // R6
endmodule

// File: rtl/scroll_reload_gate.sv
module scroll_reload_gate #(
   parameter bit GATE_ON_RENDER = 1'b1
) (
   input  logic render_en,
   input  logic hblank_stb,
   input  logic presync_stb,
   input  logic cpu_busy,
   output logic h_reload,
   output logic v_reload
);
   logic allow;
   generate
      if (GATE_ON_RENDER) begin : g_gated
         assign allow = render_en && !cpu_busy;
      end else begin : g_free
         assign allow = !cpu_busy;
      end
   endgenerate

   assign h_reload = hblank_stb  && allow;
   assign v_reload = presync_stb && allow;
endmodule

// File: rtl/scroll_vaddr_reg.sv
module scroll_vaddr_reg
   import scroll_addr_pkg::*;
#(
   parameter int unsigned ROW_STEP = 32
) (
   input  logic   clk,
   input  logic   rst_n,
   input  vaddr_t t_q,
   input  logic   step_q,
   input  logic   load_v,
   input  vaddr_t load_val,
   input  logic   inc_v,
   input  logic   h_reload,
   input  logic   v_reload,
   output vaddr_t v_q
);
   localparam vaddr_t STEP_ROW = vaddr_t'(ROW_STEP);
   localparam vaddr_t STEP_COL = vaddr_t'(1);

   vaddr_t v_d, step_amt;
   assign step_amt = step_q ? STEP_ROW : STEP_COL;

   always_comb begin
      v_d = v_q;
      if (load_v) begin
         v_d = load_val;
      end else if (inc_v) begin
         v_d = v_q + step_amt;
      end else begin
         if (h_reload) v_d = (v_d & ~HORIZ_MASK) | (t_q & HORIZ_MASK);
         if (v_reload) v_d = (v_d & ~VERT_MASK)  | (t_q & VERT_MASK);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) v_q <= '0;
      else        v_q <= v_d;
   end

   AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_v && !load_v) |=> (v_q - $past(v_q) == ($past(step_q) ? STEP_ROW : STEP_COL))); // R3
   AST_LOAD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      load_v |=> (v_q == t_q));                                        // R5
   AST_H_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (h_reload && !v_reload && !load_v && !inc_v) |=>
         ((v_q & HORIZ_MASK) == ($past(t_q) & HORIZ_MASK) &&
          (v_q & ~HORIZ_MASK) == ($past(v_q) & ~HORIZ_MASK)));          // R7
   AST_V_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (v_reload && !h_reload && !load_v && !inc_v) |=>
         ((v_q & VERT_MASK) == ($past(t_q) & VERT_MASK) &&
          (v_q & ~VERT_MASK) == ($past(v_q) & ~VERT_MASK)));            // R8
endmodule

// File: rtl/scroll_addr_unit.sv
module scroll_addr_unit
   import scroll_addr_pkg::*;
#(
   parameter int unsigned SEL_W          = 3,
   parameter int unsigned SEL_CTRL       = 0,
   parameter int unsigned SEL_STATUS     = 2,
   parameter int unsigned SEL_ADDR       = 6,
   parameter int unsigned SEL_DATA       = 7,
   parameter int unsigned OUT_W          = 14,
   parameter int unsigned ROW_STEP       = 32,
   parameter bit          GATE_ON_RENDER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_wr,
   input  logic             cpu_rd,
   input  logic [SEL_W-1:0] cpu_sel,
   input  logic [7:0]       cpu_wdata,
   input  logic             render_en,
   input  logic             hblank_stb,
   input  logic             presync_stb,
   output logic [OUT_W-1:0] vram_addr,
   output logic [14:0]      live_v
);
   localparam int unsigned SEL_SPAN = 1 << SEL_W;

   generate
      if (OUT_W > VA_W || OUT_W == 0) begin : g_bad_out
         $error("OUT_W must be between 1 and the address width");
      end
      if (SEL_CTRL >= SEL_SPAN || SEL_STATUS >= SEL_SPAN ||
          SEL_ADDR >= SEL_SPAN || SEL_DATA >= SEL_SPAN) begin : g_bad_sel
         $error("register select does not fit SEL_W");
      end
      if (SEL_CTRL == SEL_ADDR || SEL_CTRL == SEL_DATA || SEL_ADDR == SEL_DATA ||
          SEL_STATUS == SEL_CTRL || SEL_STATUS == SEL_ADDR) begin : g_bad_map
         $error("register selects must be distinct");
      end
      if (ROW_STEP == 0 || ROW_STEP >= (1 << VA_W)) begin : g_bad_step
         $error("ROW_STEP out of range");
      end
   endgenerate

   vaddr_t t_q, load_val, v_q;
   logic   step_q, load_v, inc_v, h_reload, v_reload;

   scroll_cpu_port #(
      .SEL_W(SEL_W), .SEL_CTRL(SEL_CTRL), .SEL_STATUS(SEL_STATUS),
      .SEL_ADDR(SEL_ADDR), .SEL_DATA(SEL_DATA)
   ) u_port (
      .clk(clk), .rst_n(rst_n), .wr(cpu_wr), .rd(cpu_rd), .sel(cpu_sel),
      .wdata(cpu_wdata), .t_q(t_q), .step_q(step_q), .load_v(load_v),
      .load_val(load_val), .inc_v(inc_v)
   );

   scroll_reload_gate #(.GATE_ON_RENDER(GATE_ON_RENDER)) u_gate (
      .render_en(render_en), .hblank_stb(hblank_stb), .presync_stb(presync_stb),
      .cpu_busy(load_v | inc_v), .h_reload(h_reload), .v_reload(v_reload)
   );

   scroll_vaddr_reg #(.ROW_STEP(ROW_STEP)) u_vreg (
      .clk(clk), .rst_n(rst_n), .t_q(t_q), .step_q(step_q), .load_v(load_v),
      .load_val(load_val), .inc_v(inc_v), .h_reload(h_reload),
      .v_reload(v_reload), .v_q(v_q)
   );

   assign live_v    = v_q;
   assign vram_addr = v_q[OUT_W-1:0];

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!render_en && !load_v && !inc_v) |=> $stable(live_v));          // R9
   AST_CPU_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (load_v && (hblank_stb || presync_stb)) |=> (live_v == $past(load_val))); // R11
   AST_OUT_SLICE: assert property (@(posedge clk) disable iff (!rst_n)
      vram_addr == live_v[OUT_W-1:0]);                                 // R10
endmodule

// File: tb/scroll_addr_unit_bench.sv
module scroll_addr_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
   logic [2:0]  cpu_sel = '0;
   logic [7:0]  cpu_wdata = '0;
   logic        render_en = 1'b0, hblank_stb = 1'b0, presync_stb = 1'b0;
   logic [13:0] vram_addr;
   logic [14:0] live_v;

   int n_chk = 0, n_fail = 0;
   logic [14:0] m_t, m_v;
   logic        m_step, m_tog;

   localparam logic [2:0] CTRL = 3'd0, STAT = 3'd2, ADDR = 3'd6, DATA = 3'd7;

   always #4 clk = ~clk;  // 125 MHz

   scroll_addr_unit u_scroll_addr_unit (
      .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
      .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata), .render_en(render_en),
      .hblank_stb(hblank_stb), .presync_stb(presync_stb),
      .vram_addr(vram_addr), .live_v(live_v)
   );

   task automatic chk(input string tag, input logic [14:0] exp);
      n_chk++;
      if (live_v !== exp || vram_addr !== exp[13:0]) begin
         n_fail++;
         $display("FAIL %s: live_v=%h vram_addr=%h expected %h", tag, live_v, vram_addr, exp);
      end
   endtask

   // Drive one cycle of stimulus and advance the reference model
   task automatic tick(input logic wr, input logic rd, input logic [2:0] sel,
                       input logic [7:0] d, input logic hb, input logic ps);
      logic [14:0] old_t;
      logic        cpu_v;
      @(negedge clk);
      cpu_wr = wr; cpu_rd = rd; cpu_sel = sel; cpu_wdata = d;
      hblank_stb = hb; presync_stb = ps;
      old_t = m_t; cpu_v = 1'b0;
      if (wr && sel == CTRL) begin m_t[11:10] = d[1:0]; m_step = d[2]; end
      if (wr && sel == ADDR) begin
         if (!m_tog) m_t[14:8] = {1'b0, d[5:0]};
         else begin m_t[7:0] = d; m_v = m_t; cpu_v = 1'b1; end
         m_tog = ~m_tog;
      end
      if ((wr || rd) && sel == DATA) begin
         m_v = m_v + (m_step ? 15'd32 : 15'd1); cpu_v = 1'b1;
      end
      if (rd && sel == STAT) m_tog = 1'b0;
      if (!cpu_v && render_en) begin
         if (hb) m_v = (m_v & ~15'h041F) | (old_t & 15'h041F);
         if (ps) m_v = (m_v & ~15'h7BE0) | (old_t & 15'h7BE0);
      end
      @(negedge clk);
      cpu_wr = 0; cpu_rd = 0; hblank_stb = 0; presync_stb = 0;
   endtask

   task automatic wr_reg(input logic [2:0] sel, input logic [7:0] d);
      tick(1, 0, sel, d, 0, 0);
   endtask
   task automatic rd_reg(input logic [2:0] sel);
      tick(0, 1, sel, 8'h00, 0, 0);
   endtask
   task automatic reveal_t;  // both reloads together copy all of t into v
      render_en = 1'b1;
      tick(0, 0, CTRL, 8'h00, 1, 1);
   endtask

   task automatic do_reset;
      @(negedge clk); rst_n = 0; render_en = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      m_t = '0; m_v = '0; m_step = 0; m_tog = 0;
   endtask

   task automatic test_reset;
      do_reset;
      chk("R1 reset v", 15'h0000);
      reveal_t;
      chk("R1 reset t", 15'h0000);
      rd_reg(DATA);
      chk("R1 reset step is 1", 15'h0001);
   endtask

   task automatic test_addr_pair;
      do_reset;
      wr_reg(ADDR, 8'hFF);
      chk("R4 first write keeps v", 15'h0000);
      reveal_t;
      chk("R4 first write loads t 13:8", 15'h3F00);
      wr_reg(ADDR, 8'h5A);
      chk("R5 second write loads v", 15'h3F5A);
      reveal_t;
      chk("R5 t equals v", 15'h3F5A);
   endtask

   task automatic test_ctrl;
      do_reset;
      wr_reg(ADDR, 8'h23); wr_reg(ADDR, 8'h45);
      wr_reg(CTRL, 8'h02);
      chk("R2 ctrl write keeps v", 15'h2345);
      reveal_t;
      chk("R2 ctrl sets t 11:10 only", 15'h2B45);
      wr_reg(CTRL, 8'hFD);
      reveal_t;
      chk("R2 ctrl upper data ignored", 15'h2745);
   endtask

   task automatic test_step;
      do_reset;
      wr_reg(ADDR, 8'h20); wr_reg(ADDR, 8'h10);
      rd_reg(DATA);
      chk("R3 step 1 on read", 15'h2011);
      wr_reg(CTRL, 8'h04);
      wr_reg(DATA, 8'hAA);
      chk("R3 step 32 on write", 15'h2031);
      rd_reg(DATA);
      chk("R3 step 32 on read", 15'h2051);
      wr_reg(CTRL, 8'h00);
      wr_reg(DATA, 8'h00);
      chk("R3 step back to 1", 15'h2052);
   endtask

   task automatic test_toggle;
      do_reset;
      wr_reg(ADDR, 8'h12);
      rd_reg(STAT);
      wr_reg(ADDR, 8'h34);
      chk("R6 status read restores first write", 15'h0000);
      wr_reg(ADDR, 8'h56);
      chk("R6 pair after status read", 15'h3456);
      wr_reg(ADDR, 8'h01); wr_reg(ADDR, 8'h02);
      chk("R6 toggle flips each write", 15'h0102);
   endtask

   task automatic test_hblank;
      do_reset;
      wr_reg(ADDR, 8'h2F); wr_reg(ADDR, 8'hFF);   // t = v = 0x2FFF
      wr_reg(ADDR, 8'h00); wr_reg(ADDR, 8'h00);   // t = v = 0
      wr_reg(ADDR, 8'h2F);                         // t = 0x2F00, v = 0
      wr_reg(CTRL, 8'h01);                         // t = 0x2700
      render_en = 1;
      tick(0, 0, CTRL, 8'h00, 1, 0);
      chk("R7 hblank copies bit 10 and coarse X", 15'h0400);
   endtask

   task automatic test_presync;
      do_reset;
      wr_reg(ADDR, 8'h3B); wr_reg(ADDR, 8'hFF);   // t = v = 0x3BFF
      wr_reg(ADDR, 8'h00); wr_reg(ADDR, 8'h00);
      wr_reg(ADDR, 8'h3B);                         // t = 0x3B00, v = 0
      render_en = 1;
      tick(0, 0, CTRL, 8'h00, 0, 1);
      chk("R8 presync copies vertical fields", 15'h3B00);
   endtask

   task automatic test_norender;
      do_reset;
      wr_reg(ADDR, 8'h15); wr_reg(ADDR, 8'h55);
      wr_reg(ADDR, 8'h3F);                         // t = 0x3F55, v = 0x1555
      render_en = 0;
      tick(0, 0, CTRL, 8'h00, 1, 0);
      chk("R9 hblank ignored without rendering", 15'h1555);
      tick(0, 0, CTRL, 8'h00, 0, 1);
      chk("R9 presync ignored without rendering", 15'h1555);
   endtask

   task automatic test_wrap;
      do_reset;
      wr_reg(ADDR, 8'h3F); wr_reg(ADDR, 8'hE0);
      wr_reg(CTRL, 8'h04);
      rd_reg(DATA);
      chk("R10 carry into bit 14", 15'h4000);
      for (int i = 0; i < 512; i++) rd_reg(DATA);
      chk("R10 wrap modulo 2^15", 15'h0000);
   endtask

   task automatic test_priority;
      do_reset;
      wr_reg(ADDR, 8'h00); wr_reg(ADDR, 8'h00);
      wr_reg(ADDR, 8'h12);
      render_en = 1;
      tick(1, 0, ADDR, 8'h34, 1, 1);
      chk("R11 second write beats reloads", 15'h1234);
      wr_reg(ADDR, 8'h3F);                         // t = 0x3F34, v = 0x1234
      tick(0, 1, DATA, 8'h00, 1, 1);
      chk("R11 data access beats reloads", 15'h1235);
   endtask

   task automatic test_zero;
      do_reset;
      wr_reg(ADDR, 8'h2C); wr_reg(ADDR, 8'h77);
      wr_reg(CTRL, 8'h03);
      wr_reg(ADDR, 8'h00); wr_reg(ADDR, 8'h00);
      chk("R12 zero pair clears v", 15'h0000);
      reveal_t;
      chk("R12 zero pair clears t nametable", 15'h0000);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      test_reset;
      test_addr_pair;
      test_ctrl;
      test_step;
      test_toggle;
      test_hblank;
      test_presync;
      test_norender;
      test_wrap;
      test_priority;
      test_zero;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule